// File: doc/BRIEF.md
# Luma/Chroma Byte Stream Demultiplexer

This block takes a single byte-wide video stream in which luma (Y) and colour-difference (Cb, Cr) samples are interleaved in 4:2:2 order. The bytes arrive one per clock at twice the pixel rate. The block splits the stream into a luma output that is updated at pixel rate and a Cb/Cr pair that is updated once every four bytes. A valid strobe marks each cycle that carries a fresh luma sample. The chroma pair holds between updates, so each pair spans two consecutive luma samples.

The byte order is set by two static strap inputs. One strap decides whether the first byte of a line is luma or chroma. The other decides whether the first chroma byte is Cb or Cr. Every falling edge of the active-low horizontal sync re-anchors the internal four-byte phase. A line therefore starts in a known order, whatever state the counter was in before.

A one-cycle error flag reports any byte outside its nominal range. The byte is still passed through unchanged. An upstream decoder or a line monitor can use the flag.

Top module: `ycd_demux`

## Requirements
- R1: While rst_ni is low, the outputs are black: y_o=16, cb_o=128, cr_o=128. valid_o and err_o are 0.
- R2: The phase-0 byte is the byte sampled on the rising clock edge where hsync_ni is first seen low after being high. With chroma_first_i=0, the four-byte group is luma, first chroma, luma, second chroma.
- R3: With chroma_first_i=1, the four-byte group is first chroma, luma, second chroma, luma.
- R4: With cr_first_i=0, the first chroma byte of a group is Cb and the second is Cr. With cr_first_i=1, the first is Cr and the second is Cb.
- R5: One cycle after a luma byte, valid_o is 1 and y_o equals that byte. One cycle after a chroma byte, valid_o is 0 and y_o keeps its value.
- R6: cb_o and cr_o change together, one cycle after the second chroma byte of a group. They then carry that group's Cb and Cr bytes. At all other times both outputs hold.
- R7: Each falling edge of hsync_ni resets the phase to 0, whatever the current phase. Holding hsync_ni low does not re-anchor again, and the phase keeps counting modulo 4.
- R8: err_o is 1 for exactly the cycle after one of these bytes: a luma byte outside 16..235, or a chroma byte outside 16..240. The byte still reaches y_o, cb_o or cr_o unchanged.
- R9: After reset is released, the first byte takes phase 0 even before any sync edge, whatever the phase was before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, double pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, active low; falling edge anchors the phase |
| chroma_first_i | input | 1 | Strap: 0 = luma first in group, 1 = chroma first |
| cr_first_i | input | 1 | Strap: 0 = Cb is first chroma, 1 = Cr is first chroma |
| data_i | input | 8 | Interleaved Y/Cb/Cr byte |
| y_o | output | 8 | Luma sample |
| cb_o | output | 8 | Blue-difference sample of the current pair |
| cr_o | output | 8 | Red-difference sample of the current pair |
| valid_o | output | 1 | High for one cycle with each new luma sample |
| err_o | output | 1 | One-cycle flag for an out-of-range byte |

## Verification
The bench aims sync edges at the middle of a group, where the phase is nonzero. A design that only re-anchors at group boundaries would route those bytes into the wrong lanes. It also holds sync low for more than a group. This exposes a level-sensitive anchor, which would lock the phase at zero and emit luma on every byte. All four strap combinations are used. If the second chroma byte is steered to the wrong register, or the pair is loaded one byte at a time, Cb and Cr show up swapped or half-updated. The range limits are tested on both sides of each edge: 15, 16, 235, 236, 240 and 245 for luma and chroma. An off-by-one comparator, or a check that applies the luma limit to chroma, would flag or miss one of these bytes.

// File: rtl/ycd_pkg.sv
package ycd_pkg;
  typedef enum logic [1:0] {
    KIND_Y  = 2'd0,
    KIND_CB = 2'd1,
    KIND_CR = 2'd2
  } byte_kind_e;

  localparam int unsigned GROUP_LEN = 4;
  localparam int unsigned PHASE_W   = $clog2(GROUP_LEN);
endpackage

// File: rtl/ycd_phase.sv
module ycd_phase
  import ycd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_ni,
  output logic [PHASE_W-1:0] phase_o,
  output logic               anchor_o
);
  logic               hs_q;
  logic [PHASE_W-1:0] cnt_q;

  assign anchor_o = hs_q & ~hsync_ni;
  assign phase_o  = anchor_o ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      hs_q  <= hsync_ni;
      cnt_q <= phase_o + 1'b1;
    end
  end
endmodule

// File: rtl/ycd_classify.sv
module ycd_classify
  import ycd_pkg::*;
(
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               chroma_first_i,
  input  logic               cr_first_i,
  output byte_kind_e         kind_o,
  output logic               slot_o
);
  logic is_y;
  logic is_cr;

  // even phases are luma unless chroma leads; phase MSB picks first/second chroma
  assign is_y   = (phase_i[0] == chroma_first_i);
  assign slot_o = phase_i[PHASE_W-1];
  assign is_cr  = slot_o ^ cr_first_i;

  always_comb begin
    if (is_y)       kind_o = KIND_Y;
    else if (is_cr) kind_o = KIND_CR;
    else            kind_o = KIND_CB;
  end
endmodule

// File: rtl/ycd_range.sv
module ycd_range
  import ycd_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LUMA_MIN   = 16,
  parameter int unsigned LUMA_MAX   = 235,
  parameter int unsigned CHROMA_MIN = 16,
  parameter int unsigned CHROMA_MAX = 240
) (
  input  logic [BYTE_W-1:0] data_i,
  input  byte_kind_e        kind_i,
  output logic              bad_o
);
  localparam logic [BYTE_W-1:0] LoY = BYTE_W'(LUMA_MIN);
  localparam logic [BYTE_W-1:0] HiY = BYTE_W'(LUMA_MAX);
  localparam logic [BYTE_W-1:0] LoC = BYTE_W'(CHROMA_MIN);
  localparam logic [BYTE_W-1:0] HiC = BYTE_W'(CHROMA_MAX);

  logic lo;
  logic hi;

  always_comb begin
    if (kind_i == KIND_Y) begin
      lo = data_i < LoY;
      hi = data_i > HiY;
    end else begin
      lo = data_i < LoC;
      hi = data_i > HiC;
    end
    bad_o = lo | hi;
  end
endmodule

// File: rtl/ycd_demux.sv
module ycd_demux
  import ycd_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LUMA_MIN   = 16,
  parameter int unsigned LUMA_MAX   = 235,
  parameter int unsigned CHROMA_MIN = 16,
  parameter int unsigned CHROMA_MAX = 240,
  parameter int unsigned Y_BLACK    = 16,
  parameter int unsigned C_ZERO     = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic              chroma_first_i,
  input  logic              cr_first_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] y_o,
  output logic [BYTE_W-1:0] cb_o,
  output logic [BYTE_W-1:0] cr_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam logic [BYTE_W-1:0] YBlk  = BYTE_W'(Y_BLACK);
  localparam logic [BYTE_W-1:0] CZero = BYTE_W'(C_ZERO);

  logic [PHASE_W-1:0] phase;
  logic               anchor;
  byte_kind_e         kind;
  logic               slot;
  logic               bad;
  logic               byte_is_y;
  logic               pair_first;
  logic               pair_last;

  logic [BYTE_W-1:0] y_q, cb_q, cr_q, c0_q;
  logic              valid_q, err_q;

  ycd_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_ni(hsync_ni),
    .phase_o (phase),
    .anchor_o(anchor)
  );

  ycd_classify u_cls (
    .phase_i       (phase),
    .chroma_first_i(chroma_first_i),
    .cr_first_i    (cr_first_i),
    .kind_o        (kind),
    .slot_o        (slot)
  );

  ycd_range #(
    .BYTE_W    (BYTE_W),
    .LUMA_MIN  (LUMA_MIN),
    .LUMA_MAX  (LUMA_MAX),
    .CHROMA_MIN(CHROMA_MIN),
    .CHROMA_MAX(CHROMA_MAX)
  ) u_rng (
    .data_i(data_i),
    .kind_i(kind),
    .bad_o (bad)
  );

  assign byte_is_y  = (kind == KIND_Y);
  assign pair_first = ~byte_is_y & ~slot;
  assign pair_last  = ~byte_is_y & slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= YBlk;
      cb_q    <= CZero;
      cr_q    <= CZero;
      c0_q    <= CZero;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= byte_is_y;
      err_q   <= bad;
      if (byte_is_y)  y_q  <= data_i;
      if (pair_first) c0_q <= data_i;
      // load both lanes at once so the pair never mixes groups
      if (pair_last) begin
        if (kind == KIND_CB) begin
          cb_q <= data_i;
          cr_q <= c0_q;
        end else begin
          cr_q <= data_i;
          cb_q <= c0_q;
        end
      end
    end
  end

  assign y_o     = y_q;
  assign cb_o    = cb_q;
  assign cr_o    = cr_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ycd_demux_chk.sv
module ycd_demux_chk #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LUMA_MIN   = 16,
  parameter int unsigned LUMA_MAX   = 235,
  parameter int unsigned CHROMA_MIN = 16,
  parameter int unsigned CHROMA_MAX = 240,
  parameter int unsigned Y_BLACK    = 16,
  parameter int unsigned C_ZERO     = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_ni,
  input logic              chroma_first_i,
  input logic [BYTE_W-1:0] data_i,
  input logic              byte_is_y,
  input logic              pair_last,
  input logic [BYTE_W-1:0] y_o,
  input logic [BYTE_W-1:0] cb_o,
  input logic [BYTE_W-1:0] cr_o,
  input logic              valid_o,
  input logic              err_o
);
  localparam logic [BYTE_W-1:0] YBlk  = BYTE_W'(Y_BLACK);
  localparam logic [BYTE_W-1:0] CZero = BYTE_W'(C_ZERO);
  localparam logic [BYTE_W-1:0] LoY   = BYTE_W'(LUMA_MIN);
  localparam logic [BYTE_W-1:0] HiY   = BYTE_W'(LUMA_MAX);

  logic hs_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_prev <= 1'b1;
    else         hs_prev <= hsync_ni;
  end

  AST_RESET_BLACK: assert property (@(posedge clk_i)
    !rst_ni |=> (y_o == YBlk && cb_o == CZero && cr_o == CZero && !valid_o && !err_o)); // R1

  AST_LUMA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_prev && !hsync_ni && !chroma_first_i) |=> valid_o); // R2

  AST_CHROMA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_prev && !hsync_ni && chroma_first_i) |=> !valid_o); // R3

  AST_LUMA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_is_y |=> (valid_o && y_o == $past(data_i))); // R5

  AST_CHROMA_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_is_y |=> (!valid_o && $stable(y_o))); // R5

  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_last |=> ($stable(cb_o) && $stable(cr_o))); // R6

  AST_LUMA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_is_y && (data_i < LoY || data_i > HiY)) |=> err_o); // R8
endmodule

bind ycd_demux ycd_demux_chk #(
  .BYTE_W    (BYTE_W),
  .LUMA_MIN  (LUMA_MIN),
  .LUMA_MAX  (LUMA_MAX),
  .CHROMA_MIN(CHROMA_MIN),
  .CHROMA_MAX(CHROMA_MAX),
  .Y_BLACK   (Y_BLACK),
  .C_ZERO    (C_ZERO)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hsync_ni      (hsync_ni),
  .chroma_first_i(chroma_first_i),
  .data_i        (data_i),
  .byte_is_y     (byte_is_y),
  .pair_last     (pair_last),
  .y_o           (y_o),
  .cb_o          (cb_o),
  .cr_o          (cr_o),
  .valid_o       (valid_o),
  .err_o         (err_o)
);

// File: tb/ycd_demux_test.sv
module ycd_demux_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_ni = 1'b1;
  logic       chroma_first_i = 1'b0;
  logic       cr_first_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] y_o, cb_o, cr_o;
  logic       valid_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  ycd_demux uut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hsync_ni      (hsync_ni),
    .chroma_first_i(chroma_first_i),
    .cr_first_i    (cr_first_i),
    .data_i        (data_i),
    .y_o           (y_o),
    .cb_o          (cb_o),
    .cr_o          (cr_o),
    .valid_o       (valid_o),
    .err_o         (err_o)
  );

  // {hs, chroma_first, cr_first, data, exp_valid, exp_y, exp_cb, exp_cr, exp_err}
  localparam int NV = 29;
  localparam logic [36:0] VECS [NV] = '{
    {3'b100, 8'h50, 1'b1, 8'h50, 8'h80, 8'h80, 1'b0}, // R9 phase 0 before any sync
    {3'b000, 8'h20, 1'b1, 8'h20, 8'h80, 8'h80, 1'b0}, // R7 anchor at phase 1, R2 luma first
    {3'b000, 8'h60, 1'b0, 8'h20, 8'h80, 8'h80, 1'b0}, // R4 first chroma Cb held
    {3'b000, 8'h70, 1'b1, 8'h70, 8'h80, 8'h80, 1'b0},
    {3'b000, 8'hA0, 1'b0, 8'h70, 8'h60, 8'hA0, 1'b0}, // R6 pair loads
    {3'b100, 8'h05, 1'b1, 8'h05, 8'h60, 8'hA0, 1'b1}, // R8 low luma passed through
    {3'b100, 8'hF5, 1'b0, 8'h05, 8'h60, 8'hA0, 1'b1}, // R8 chroma 245
    {3'b100, 8'hEB, 1'b1, 8'hEB, 8'h60, 8'hA0, 1'b0}, // R8 luma 235 ok
    {3'b100, 8'h10, 1'b0, 8'hEB, 8'hF5, 8'h10, 1'b0}, // R8 chroma 16 ok
    {3'b000, 8'hEC, 1'b1, 8'hEC, 8'hF5, 8'h10, 1'b1}, // R8 luma 236
    {3'b100, 8'hF0, 1'b0, 8'hEC, 8'hF5, 8'h10, 1'b0}, // R8 chroma 240 ok
    {3'b000, 8'h0F, 1'b1, 8'h0F, 8'hF5, 8'h10, 1'b1}, // R7 mid-group anchor, R8 luma 15
    {3'b111, 8'h40, 1'b1, 8'h40, 8'hF5, 8'h10, 1'b0}, // R3 phase 1 is luma
    {3'b011, 8'h80, 1'b0, 8'h40, 8'hF5, 8'h10, 1'b0}, // R3 R4 anchor, first chroma Cr
    {3'b011, 8'h30, 1'b1, 8'h30, 8'hF5, 8'h10, 1'b0},
    {3'b011, 8'h90, 1'b0, 8'h30, 8'h90, 8'h80, 1'b0}, // R4 R6 second chroma Cb
    {3'b011, 8'h31, 1'b1, 8'h31, 8'h90, 8'h80, 1'b0},
    {3'b011, 8'h91, 1'b0, 8'h31, 8'h90, 8'h80, 1'b0}, // R7 low level, no re-anchor
    {3'b011, 8'h11, 1'b1, 8'h11, 8'h90, 8'h80, 1'b0},
    {3'b011, 8'h0E, 1'b0, 8'h11, 8'h0E, 8'h91, 1'b1}, // R8 chroma 14
    {3'b101, 8'h22, 1'b0, 8'h11, 8'h22, 8'h91, 1'b0}, // R4 phase 3 second chroma Cb
    {3'b001, 8'h55, 1'b1, 8'h55, 8'h22, 8'h91, 1'b0}, // R2 anchor
    {3'b001, 8'h66, 1'b0, 8'h55, 8'h22, 8'h91, 1'b0},
    {3'b001, 8'h56, 1'b1, 8'h56, 8'h22, 8'h91, 1'b0},
    {3'b001, 8'h77, 1'b0, 8'h56, 8'h77, 8'h66, 1'b0}, // R4 R6 Cr first then Cb
    {3'b110, 8'h12, 1'b0, 8'h56, 8'h77, 8'h66, 1'b0}, // R3 phase 0 chroma
    {3'b010, 8'h34, 1'b0, 8'h56, 8'h77, 8'h66, 1'b0}, // R7 anchor on chroma
    {3'b010, 8'h35, 1'b1, 8'h35, 8'h77, 8'h66, 1'b0},
    {3'b010, 8'h44, 1'b0, 8'h35, 8'h34, 8'h44, 1'b0}  // R6 anchor dropped stale 0x12
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string tag, input logic [25:0] exp);
    logic [25:0] got;
    got = {valid_o, y_o, cb_o, cr_o, err_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual v=%0b y=%h cb=%h cr=%h e=%0b expected v=%0b y=%h cb=%h cr=%h e=%0b",
               tag, got[25], got[24:17], got[16:9], got[8:1], got[0],
               exp[25], exp[24:17], exp[16:9], exp[8:1], exp[0]);
    end
  endtask

  task automatic drive(input logic hs, input logic cf, input logic rf, input logic [7:0] d);
    hsync_ni = hs; chroma_first_i = cf; cr_first_i = rf; data_i = d;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset state", {1'b0, 8'h10, 8'h80, 8'h80, 1'b0});
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][36], VECS[i][35], VECS[i][34], VECS[i][33:26]);
      @(negedge clk_i);
      check($sformatf("vector %0d R2 R3 R4 R5 R6 R7 R8", i), VECS[i][25:0]);
    end
    // reset mid-stream with an out-of-range byte present
    rst_ni = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    #2;
    check("R1 async reset mid-stream", {1'b0, 8'h10, 8'h80, 8'h80, 1'b0});
    @(negedge clk_i);
    check("R1 reset held over edge", {1'b0, 8'h10, 8'h80, 8'h80, 1'b0});
    rst_ni = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 8'h21);
    @(negedge clk_i);
    check("R9 phase restarts at luma", {1'b1, 8'h21, 8'h80, 8'h80, 1'b0});
    drive(1'b1, 1'b0, 1'b0, 8'h81);
    @(negedge clk_i);
    check("R9 phase 1 chroma", {1'b0, 8'h21, 8'h80, 8'h80, 1'b0});
    drive(1'b1, 1'b0, 1'b0, 8'h22);
    @(negedge clk_i);
    check("R9 phase 2 luma", {1'b1, 8'h22, 8'h80, 8'h80, 1'b0});
    drive(1'b1, 1'b0, 1'b0, 8'h82);
    @(negedge clk_i);
    check("R6 pair after reset", {1'b0, 8'h22, 8'h81, 8'h82, 1'b0});
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule